// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block controls shutdown and restart for a clock generator that has several output groups. An active-low power-down request arrives with no timing relation to the internal CPU-domain clock, so the block first passes it through a chain of flops. It then closes the gates of the CPU, PCI, reference and 48 MHz output groups on a falling clock edge. It waits for the reference path to confirm that its output is parked low. Only then does it switch off the VCO, and after that the crystal oscillator.

Releasing the request starts the restart. The oscillator comes back first and is given a start-up window. The VCO is then given a lock window. Both windows are counted in ticks of a slow, always-on timebase. All output gates then reopen together on one falling edge.

Outside a power-down, two active-low stop requests can each hold one output group low. Whenever the block is not in its running state, both stop requests are ignored.

Top module: `pd_seq_top`

## Requirements
- R1: `pwrdn_req_n` passes through `SYNC_STAGES` flops (default 2) before it acts. A level driven shortly after rising edge k first changes the state at rising edge k+3, which is when `clocks_running` falls.
- R2: On the first falling edge after `clocks_running` goes low, all four gates go low: `cpu_clk_en`, `pci_clk_en`, `ref_clk_en` and `clk48_en`.
- R3: `vco_en` stays high until `ref_parked_ack` (active high) is seen, however long the acknowledge takes.
- R4: `vco_en` falls only while all four gates are low. `xtal_en` falls one cycle after `vco_en` and is never low while `vco_en` is high.
- R5: While the block is not running, `cpu_halt_n` and `pci_halt_n` have no effect on any output.
- R6: While running, `cpu_halt_n` low drives only `cpu_clk_en` low, and `cpu_halt_n` high drives it high again. Each change happens on the next falling edge.
- R7: While running, `pci_halt_n` low drives only `pci_clk_en` low, and `pci_halt_n` high drives it high again. Each change happens on the next falling edge. The free-running PCI output is not gated here.
- R8: On release, `xtal_en` rises first. After `XTAL_TICKS` one-cycle `slow_tick` pulses, `vco_en` rises. After `LOCK_TICKS` more pulses, `clocks_running` rises. All unstopped gates then rise on the same falling edge. At elaboration, the sum of the two windows must be less than 3 ms.
- R9: `clocks_running` is high only in the running state. Reset is synchronous and active high, and it puts the block in the running state with every enable high.
- R10: If the request is released before the shutdown has finished, the shutdown still completes, with the crystal turned off, before the restart begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | One-cycle pulse from the always-on timebase |
| pwrdn_req_n | input | 1 | Asynchronous power-down request, active low |
| cpu_halt_n | input | 1 | CPU group stop request, active low |
| pci_halt_n | input | 1 | PCI group stop request, active low |
| ref_parked_ack | input | 1 | Reference output confirmed parked low |
| cpu_clk_en | output | 1 | CPU group gate, changes on falling edge |
| pci_clk_en | output | 1 | PCI group gate, changes on falling edge |
| ref_clk_en | output | 1 | Reference group gate, changes on falling edge |
| clk48_en | output | 1 | 48 MHz group gate, changes on falling edge |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| clocks_running | output | 1 | High only in the running state |

## Verification
The assertions rely on the following inputs:
- `slow_tick` is a single-cycle pulse.
- The halt inputs and `ref_parked_ack` are synchronous to `clk`.
- `ref_parked_ack` rises only after the reference gate has closed.

The bench drives every input a fixed offset after a rising edge. Its acknowledge model asserts `ref_parked_ack` only once `ref_clk_en` has been low for a programmed number of cycles. For one test it holds the acknowledge back on purpose, so that a release can be placed partway through the shutdown.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_GATE      = 3'd1,
    ST_PARK_WAIT = 3'd2,
    ST_VCO_OFF   = 3'd3,
    ST_XTAL_OFF  = 3'd4,
    ST_DOWN      = 3'd5,
    ST_XTAL_ON   = 3'd6,
    ST_LOCK_WAIT = 3'd7
  } pd_state_e;

  localparam int GRP_CPU = 0;
  localparam int GRP_PCI = 1;
  localparam int GRP_REF = 2;
  localparam int GRP_48  = 3;
  localparam int NUM_GRP = 4;

  // VCO runs everywhere except from its shutdown up to the end of oscillator start-up
  function automatic logic vco_on(pd_state_e s);
    return !(s inside {ST_VCO_OFF, ST_XTAL_OFF, ST_DOWN, ST_XTAL_ON});
  endfunction

  function automatic logic xtal_on(pd_state_e s);
    return !(s inside {ST_XTAL_OFF, ST_DOWN});
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_seq_pkg::*;
#(
  parameter int XTAL_TICKS = 100,
  parameter int LOCK_TICKS = 50,
  parameter int TICK_US    = 10,
  parameter int LIMIT_US   = 3000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req_n_s,
  input  logic      tick,
  input  logic      ref_parked,
  output pd_state_e state,
  output logic      vco_en,
  output logic      xtal_en,
  output logic      run_flag
);

  localparam int MAX_TICKS  = (XTAL_TICKS > LOCK_TICKS) ? XTAL_TICKS : LOCK_TICKS;
  localparam int CNT_W      = $clog2(MAX_TICKS + 1);
  localparam int RESTART_US = (XTAL_TICKS + LOCK_TICKS) * TICK_US;

  generate
    if (RESTART_US >= LIMIT_US) begin : g_bad_windows
      $error("pd_fsm: restart windows exceed the power-up latency limit");
    end
  endgenerate

  pd_state_e        nxt;
  logic [CNT_W-1:0] cnt;
  logic             counting;

  assign counting = (state == ST_XTAL_ON) || (state == ST_LOCK_WAIT);

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:       if (!req_n_s) nxt = ST_GATE;
      ST_GATE:      nxt = ST_PARK_WAIT;
      ST_PARK_WAIT: if (ref_parked) nxt = ST_VCO_OFF;
      ST_VCO_OFF:   nxt = ST_XTAL_OFF;
      ST_XTAL_OFF:  nxt = ST_DOWN;
      ST_DOWN:      if (req_n_s) nxt = ST_XTAL_ON;
      ST_XTAL_ON:   if (tick && cnt == CNT_W'(XTAL_TICKS - 1)) nxt = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (tick && cnt == CNT_W'(LOCK_TICKS - 1)) nxt = ST_RUN;
      default:      nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      cnt      <= '0;
      vco_en   <= 1'b1;
      xtal_en  <= 1'b1;
      run_flag <= 1'b1;
    end else begin
      state    <= nxt;
      vco_en   <= vco_on(nxt);
      xtal_en  <= xtal_on(nxt);
      run_flag <= (nxt == ST_RUN);
      if (nxt != state)           cnt <= '0;
      else if (counting && tick)  cnt <= cnt + 1'b1;
    end
  end

  // r3: VCO stays on while the reference park acknowledge is outstanding
  p_park_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARK_WAIT && !ref_parked) |=> vco_en);

  // r10: a release seen mid-shutdown never jumps straight to restart
  p_shutdown_completes_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARK_WAIT && req_n_s) |=> (state != ST_XTAL_ON && state != ST_LOCK_WAIT));

endmodule

// File: rtl/pd_gate_bank.sv
module pd_gate_bank #(
  parameter int NUM_GRP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               allow,
  input  logic [NUM_GRP-1:0] hold_n,
  output logic [NUM_GRP-1:0] en
);

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_grp
      logic q;
      // falling-edge update keeps the downstream gated clock free of runts
      always_ff @(negedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= allow & hold_n[g];
      end
      assign en[g] = q;
    end
  endgenerate

endmodule

// File: rtl/pd_seq_top.sv
module pd_seq_top
  import pd_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int XTAL_TICKS  = 100,
  parameter int LOCK_TICKS  = 50,
  parameter int TICK_US     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic pwrdn_req_n,
  input  logic cpu_halt_n,
  input  logic pci_halt_n,
  input  logic ref_parked_ack,
  output logic cpu_clk_en,
  output logic pci_clk_en,
  output logic ref_clk_en,
  output logic clk48_en,
  output logic vco_en,
  output logic xtal_en,
  output logic clocks_running
);

  logic               req_n_s;
  pd_state_e          state;
  logic [NUM_GRP-1:0] hold_n;
  logic [NUM_GRP-1:0] gate_en;

  pd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pwrdn_req_n),
    .sync_out (req_n_s)
  );

  pd_fsm #(
    .XTAL_TICKS (XTAL_TICKS),
    .LOCK_TICKS (LOCK_TICKS),
    .TICK_US    (TICK_US),
    .LIMIT_US   (3000)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_n_s    (req_n_s),
    .tick       (slow_tick),
    .ref_parked (ref_parked_ack),
    .state      (state),
    .vco_en     (vco_en),
    .xtal_en    (xtal_en),
    .run_flag   (clocks_running)
  );

  always_comb begin
    hold_n          = '1;
    hold_n[GRP_CPU] = cpu_halt_n;
    hold_n[GRP_PCI] = pci_halt_n;
  end

  pd_gate_bank #(.NUM_GRP(NUM_GRP)) u_gates (
    .clk    (clk),
    .rst    (rst),
    .allow  (clocks_running),
    .hold_n (hold_n),
    .en     (gate_en)
  );

  assign cpu_clk_en = gate_en[GRP_CPU];
  assign pci_clk_en = gate_en[GRP_PCI];
  assign ref_clk_en = gate_en[GRP_REF];
  assign clk48_en   = gate_en[GRP_48];

  // r4: VCO only drops once every output group is parked
  p_vco_after_gates_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(vco_en) |-> (gate_en == '0));

  // r4: crystal never off while the VCO is still on
  p_xtal_after_vco_r4: assert property (@(posedge clk) disable iff (rst)
    !xtal_en |-> !vco_en);

  // r9: running implies both sources enabled
  p_run_sources_r9: assert property (@(posedge clk) disable iff (rst)
    clocks_running |-> (vco_en && xtal_en));

  // r5: gates stay closed whenever the VCO is off
  p_closed_when_down_r5: assert property (@(posedge clk) disable iff (rst)
    !vco_en |-> (gate_en == '0));

endmodule

// File: tb/pd_seq_top_tb.sv
`timescale 1ns/1ps
module pd_seq_top_tb;

  localparam int XT = 3;
  localparam int LK = 2;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic pwrdn_req_n = 1'b1;
  logic cpu_halt_n = 1'b1;
  logic pci_halt_n = 1'b1;
  logic ref_parked_ack = 1'b0;
  logic cpu_clk_en, pci_clk_en, ref_clk_en, clk48_en, vco_en, xtal_en, clocks_running;

  int n_chk = 0;
  int n_bad = 0;
  int ref_dly = 1;
  bit hold_ack = 1'b0;
  bit restarting = 1'b0;
  int xt_seen = 0;
  int lk_seen = 0;

  always #4 clk = ~clk;

  pd_seq_top #(.SYNC_STAGES(2), .XTAL_TICKS(XT), .LOCK_TICKS(LK), .TICK_US(100)) u_dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .pwrdn_req_n(pwrdn_req_n),
    .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n), .ref_parked_ack(ref_parked_ack),
    .cpu_clk_en(cpu_clk_en), .pci_clk_en(pci_clk_en), .ref_clk_en(ref_clk_en),
    .clk48_en(clk48_en), .vco_en(vco_en), .xtal_en(xtal_en), .clocks_running(clocks_running)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] gates();
    return {clk48_en, ref_clk_en, pci_clk_en, cpu_clk_en};
  endfunction

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // timebase and reference-park acknowledge models, driven after the rising edge
  int tdiv = 0;
  int park_cnt = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % TICK_DIV;
    slow_tick = (tdiv == 0);
    if (ref_clk_en) begin
      park_cnt = 0;
      ref_parked_ack = 1'b0;
    end else if (!hold_ack) begin
      park_cnt++;
      ref_parked_ack = (park_cnt >= ref_dly);
    end
  end

  // tick counting of the restart windows (pre-edge values)
  always @(posedge clk) begin
    if (!rst && restarting && slow_tick) begin
      if (xtal_en && !vco_en) xt_seen++;
      if (vco_en && !clocks_running) lk_seen++;
    end
  end

  // ordering monitor: R4
  logic prev_vco = 1'b1;
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (!xtal_en && vco_en) check("R4 xtal off with vco on", 8'd1, 8'd0);
      if (prev_vco && !vco_en) check("R4 gates at vco off", {4'd0, gates()}, 8'h0);
    end
    prev_vco = vco_en;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_sig(input string what, input int which, input logic val);
    int k;
    for (k = 0; k < 400; k++) begin
      if ((which == 0 ? xtal_en : clocks_running) === val) break;
      cyc(1);
    end
    if (k == 400) check(what, 8'd0, 8'd1);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    cyc(4);
    // R9: reset state
    check("R9 reset gates", {4'd0, gates()}, 8'hF);
    check("R9 reset sources", {6'd0, vco_en, xtal_en}, 8'h3);
    check("R9 reset run flag", {7'd0, clocks_running}, 8'h1);
    rst = 1'b0;
    cyc(3);

    // R6 / R7: stops while running, one group each, on the falling edge
    for (int grp = 0; grp < 2; grp++) begin
      if (grp == 0) cpu_halt_n = 1'b0; else pci_halt_n = 1'b0;
      #1;
      check(grp == 0 ? "R6 before falling edge" : "R7 before falling edge", {4'd0, gates()}, 8'hF);
      #4;
      check(grp == 0 ? "R6 stop applied" : "R7 stop applied", {4'd0, gates()},
            grp == 0 ? 8'hE : 8'hD);
      check(grp == 0 ? "R6 run flag kept" : "R7 run flag kept", {7'd0, clocks_running}, 8'h1);
      cyc(2);
      cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
      #5;
      check(grp == 0 ? "R6 stop released" : "R7 stop released", {4'd0, gates()}, 8'hF);
      cyc(2);
    end

    // sweep: park delay x stop pattern during power-down and restart
    for (int d = 1; d <= 3; d++) begin
      for (int combo = 0; combo < 4; combo++) begin
        ref_dly = d;
        pwrdn_req_n = 1'b0;          // driven after edge k
        cyc(1);                      // edge k+1
        cyc(1);                      // edge k+2
        #1;
        check("R1 run flag before sync", {7'd0, clocks_running}, 8'h1);
        @(posedge clk); #2;          // edge k+3
        check("R1 run flag after sync", {7'd0, clocks_running}, 8'h0);
        check("R2 gates before falling edge", {4'd0, gates()}, 8'hF);
        #4;
        check("R2 gates parked", {4'd0, gates()}, 8'h0);
        check("R3 vco held until ack", {7'd0, vco_en}, 8'h1);
        cpu_halt_n = combo[0]; pci_halt_n = combo[1];
        wait_sig("R4 crystal shut", 0, 1'b0);
        check("R4 vco off", {7'd0, vco_en}, 8'h0);
        cpu_halt_n = ~combo[0]; pci_halt_n = ~combo[1];
        cyc(3);
        check("R5 stops ignored while down", {4'd0, gates()}, 8'h0);
        cpu_halt_n = combo[0]; pci_halt_n = combo[1];
        xt_seen = 0; lk_seen = 0; restarting = 1'b1;
        pwrdn_req_n = 1'b1;
        wait_sig("R8 restart", 1, 1'b1);
        restarting = 1'b0;
        check("R8 crystal window ticks", 8'(xt_seen), 8'(XT));
        check("R8 lock window ticks", 8'(lk_seen), 8'(LK));
        check("R8 gates closed until falling edge", {4'd0, gates()}, 8'h0);
        #4;
        check("R8 gates reopen together", {4'd0, gates()},
              {4'd0, 2'b11, combo[1], combo[0]});
        cpu_halt_n = 1'b1; pci_halt_n = 1'b1;
        cyc(2);
      end
    end

    // R10: release during shutdown with acknowledge held back
    hold_ack = 1'b1;
    ref_dly = 2;
    pwrdn_req_n = 1'b0;
    cyc(8);
    pwrdn_req_n = 1'b1;
    cyc(10);
    check("R10 still waiting on park", {5'd0, vco_en, xtal_en, clocks_running}, 8'h6);
    hold_ack = 1'b0;
    wait_sig("R10 shutdown completed", 0, 1'b0);
    check("R10 vco off before restart", {7'd0, vco_en}, 8'h0);
    wait_sig("R10 restart after shutdown", 1, 1'b1);
    cyc(1);
    check("R10 gates back", {4'd0, gates()}, 8'hF);

    // R9: reset in the middle of a power-down returns everything on
    pwrdn_req_n = 1'b0;
    wait_sig("R9 reach down", 0, 1'b0);
    rst = 1'b1;
    cyc(2);
    check("R9 reset from down", {3'd0, vco_en, xtal_en, clocks_running, ref_clk_en, cpu_clk_en}, 8'h1F);
    pwrdn_req_n = 1'b1;
    rst = 1'b0;
    cyc(4);
    check("R9 run after reset", {7'd0, clocks_running}, 8'h1);

    finish_up();
  end

endmodule